// File: doc/BRIEF.md
# Transfer Descriptor Load/Writeback Sequencer

This block runs one activation of a descriptor-driven transfer controller. An activation request carries the byte address of a descriptor. The descriptor is six consecutive 32-bit words in memory. The sequencer reads all six words, one at a time, into private working registers through a single-beat memory port. It then starts an external transfer engine, which sees the loaded values on dedicated outputs. When the engine reports done, the sequencer captures the updated values the engine presents and writes them back to the same six locations. It then raises a one-cycle completion event that other peripherals can use as a trigger.

No processor path reaches the working registers. They are refilled from memory on every activation and stored back when it ends, so the descriptor in memory is the only state that lasts between activations. One request that arrives while an activation is in progress is remembered, together with its base address, and is served once the sequencer is idle again. Moving the data, arbitrating between several requesters and looking up descriptor base addresses are left to neighbouring blocks.

Top module: `xfer_desc_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy`, `done_evt`, `mem_req` and `eng_start` are all low.
- R2: An activation first issues exactly six reads (`mem_we`=0) at base+4·k for k=0..5, in the word order mode A (k=0), mode B (1), source (2), destination (3), count A (4), count B (5). A read is issued only after the data of the previous read has returned, so with an immediate grant and one-cycle read data, consecutive reads are granted two cycles apart.
- R3: `eng_start` is a one-cycle pulse in the cycle after the sixth read data returns. At that time the `eng_*` outputs carry the six words that were read.
- R4: While the engine runs, from `eng_start` until `eng_done`, the sequencer issues no memory request. In the cycle `eng_done` is high, it captures the six `eng_upd_*` values.
- R5: After `eng_done`, the sequencer issues exactly six writes (`mem_we`=1) to base+4·k, k=0..5, in the same word order as the reads. The write data is the captured updated values.
- R6: A memory request that is not granted is held the next cycle with the same address, direction and write data.
- R7: `done_evt` is high for exactly one cycle per activation. That cycle directly follows the cycle in which the last write-back write was granted; the event waits for nothing beyond that grant.
- R8: `busy` rises in the cycle after a request is accepted and stays high through the `done_evt` cycle. It is low in the cycle after `done_evt`, unless a pending request is then launched.
- R9: A request that arrives while the sequencer is not idle is kept in a single pending slot together with its base. Its first read is issued two cycles after the `done_evt` of the current activation. Further requests that arrive while the slot is already full are dropped and cause no memory access.
- R10: No working value survives from one activation to the next. If the memory descriptor changes between two activations at the same base, the engine sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation request, one cycle per request |
| act_base | input | ADDR_W | Byte address of the descriptor, valid with act_req |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after the grant |
| mem_rdata | input | DATA_W | Read data |
| eng_start | output | 1 | One-cycle start pulse to the transfer engine |
| eng_mode_a | output | DATA_W | Working mode word A |
| eng_mode_b | output | DATA_W | Working mode word B |
| eng_src | output | DATA_W | Working source address |
| eng_dst | output | DATA_W | Working destination address |
| eng_cnt_a | output | DATA_W | Working count word A |
| eng_cnt_b | output | DATA_W | Working count word B |
| eng_done | input | 1 | Engine finished; updated values valid |
| eng_upd_mode_a | input | DATA_W | Updated mode word A |
| eng_upd_mode_b | input | DATA_W | Updated mode word B |
| eng_upd_src | input | DATA_W | Updated source address |
| eng_upd_dst | input | DATA_W | Updated destination address |
| eng_upd_cnt_a | input | DATA_W | Updated count word A |
| eng_upd_cnt_b | input | DATA_W | Updated count word B |
| busy | output | 1 | Activation in progress |
| done_evt | output | 1 | One-cycle completion event |

## Verification
The bench holds back memory grants so that requests have to wait. A design that moved the address or let data drift during a stall would store words at the wrong location. It also checks that every read waits for the previous data to return and that the engine starts exactly one cycle after the last word arrives; a sequencer that started early would hand the engine a stale count word. Requests are sent while an activation is running, one to be held pending and one more to be dropped. A design that lost the pending base, or served the extra request, would leave an untouched descriptor modified or skip the second one. Finally, the descriptor is rewritten between two activations at the same base. A design that kept old working values would pass stale words to the engine.

// File: rtl/xds_pkg.sv
package xds_pkg;
   localparam int DESC_WORDS = 6;
   localparam int IDX_W      = $clog2(DESC_WORDS);

   localparam int WI_MODE_A = 0;
   localparam int WI_MODE_B = 1;
   localparam int WI_SRC    = 2;
   localparam int WI_DST    = 3;
   localparam int WI_CNT_A  = 4;
   localparam int WI_CNT_B  = 5;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_FETCH = 3'd1,
      S_RUN   = 3'd2,
      S_WBACK = 3'd3,
      S_EVENT = 3'd4
   } seq_state_t;
endpackage

// File: rtl/xds_addr_gen.sv
module xds_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int IDX_W      = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam bit POW2  = (WORD_BYTES & (WORD_BYTES - 1)) == 0;
   localparam int SHIFT = $clog2(WORD_BYTES);

   initial begin
      AST_WORD_BYTES_POS: assert (WORD_BYTES > 0);
      AST_IDX_FITS: assert (IDX_W < ADDR_W);
   end

   generate
      if (POW2) begin : g_shift
         assign addr = base + (ADDR_W'(idx) << SHIFT);
      end else begin : g_mult
         assign addr = base + ADDR_W'(idx) * ADDR_W'(WORD_BYTES);
      end
   endgenerate
endmodule

// File: rtl/xds_regfile.sv
module xds_regfile #(
   parameter int DATA_W = 32,
   parameter int NWORDS = 6,
   parameter int IDX_W  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld_en,
   input  logic [IDX_W-1:0]              ld_idx,
   input  logic [DATA_W-1:0]             ld_data,
   input  logic                          upd_en,
   input  logic [NWORDS-1:0][DATA_W-1:0] upd_data,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [NWORDS-1:0][DATA_W-1:0] regs,
   output logic [DATA_W-1:0]             rd_data
);
   initial begin
      AST_NWORDS_FIT: assert (NWORDS <= (1 << IDX_W));
   end

   generate
      for (genvar g = 0; g < NWORDS; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs[g] <= '0;
            end else if (upd_en) begin
               regs[g] <= upd_data[g];
            end else if (ld_en && (ld_idx == IDX_W'(g))) begin
               regs[g] <= ld_data;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NWORDS; k++) begin
         if (rd_idx == IDX_W'(k)) rd_data = regs[k];
      end
   end

   AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_en && upd_en)); // R4
endmodule

// File: rtl/xds_ctrl.sv
module xds_ctrl
   import xds_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NWORDS = 6,
   parameter int IW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_req,
   input  logic [ADDR_W-1:0] act_base,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic              eng_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [IW-1:0]     cur_idx,
   output logic [ADDR_W-1:0] cur_base,
   output logic              ld_en,
   output logic              upd_en,
   output logic              eng_start,
   output logic              busy,
   output logic              done_evt
);
   localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

   seq_state_t        state_q;
   logic [IW-1:0]     idx_q;
   logic              rd_wait_q;
   logic              start_q;
   logic              pend_q;
   logic [ADDR_W-1:0] pend_base_q;
   logic [ADDR_W-1:0] base_q;
   logic              idle;

   assign idle = (state_q == S_IDLE);

   // pending slot and active base
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_base_q <= '0;
         base_q      <= '0;
      end else if (idle) begin
         if (pend_q) begin
            base_q <= pend_base_q;
            pend_q <= act_req;
            if (act_req) pend_base_q <= act_base;
         end else if (act_req) begin
            base_q <= act_base;
         end
      end else if (act_req && !pend_q) begin
         pend_q      <= 1'b1;
         pend_base_q <= act_base;
      end
   end

   // activation sequence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         idx_q     <= '0;
         rd_wait_q <= 1'b0;
         start_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (act_req || pend_q) begin
                  state_q   <= S_FETCH;
                  idx_q     <= '0;
                  rd_wait_q <= 1'b0;
               end
            end
            S_FETCH: begin
               if (!rd_wait_q) begin
                  if (mem_gnt) rd_wait_q <= 1'b1;
               end else if (mem_rvalid) begin
                  rd_wait_q <= 1'b0;
                  if (idx_q == LAST_IDX) begin
                     state_q <= S_RUN;
                     start_q <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            S_RUN: begin
               if (eng_done) begin
                  state_q <= S_WBACK;
                  idx_q   <= '0;
               end
            end
            S_WBACK: begin
               if (mem_gnt) begin
                  if (idx_q == LAST_IDX) state_q <= S_EVENT;
                  else                   idx_q   <= idx_q + 1'b1;
               end
            end
            S_EVENT: state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign mem_req   = ((state_q == S_FETCH) && !rd_wait_q) || (state_q == S_WBACK);
   assign mem_we    = (state_q == S_WBACK);
   assign cur_idx   = idx_q;
   assign cur_base  = base_q;
   assign ld_en     = (state_q == S_FETCH) && rd_wait_q && mem_rvalid;
   assign upd_en    = (state_q == S_RUN) && eng_done;
   assign eng_start = start_q;
   assign busy      = !idle;
   assign done_evt  = (state_q == S_EVENT);

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX); // R2
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(idx_q) && $stable(mem_we)); // R6
   AST_START_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> $past(mem_rvalid)); // R3
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start); // R3
   AST_EVT_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |-> $past(mem_gnt && mem_we)); // R7
   AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> !done_evt); // R7
   AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !idle |=> pend_q); // R9
endmodule

// File: rtl/xfer_desc_seq.sv
module xfer_desc_seq
   import xds_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_req,
   input  logic [ADDR_W-1:0] act_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              eng_start,
   output logic [DATA_W-1:0] eng_mode_a,
   output logic [DATA_W-1:0] eng_mode_b,
   output logic [DATA_W-1:0] eng_src,
   output logic [DATA_W-1:0] eng_dst,
   output logic [DATA_W-1:0] eng_cnt_a,
   output logic [DATA_W-1:0] eng_cnt_b,
   input  logic              eng_done,
   input  logic [DATA_W-1:0] eng_upd_mode_a,
   input  logic [DATA_W-1:0] eng_upd_mode_b,
   input  logic [DATA_W-1:0] eng_upd_src,
   input  logic [DATA_W-1:0] eng_upd_dst,
   input  logic [DATA_W-1:0] eng_upd_cnt_a,
   input  logic [DATA_W-1:0] eng_upd_cnt_b,
   output logic              busy,
   output logic              done_evt
);
   localparam int WORD_BYTES = DATA_W / 8;

   initial begin
      AST_DATA_BYTES: assert (DATA_W % 8 == 0 && DATA_W >= 8);
      AST_ADDR_WIDE: assert (ADDR_W >= 8);
   end

   logic [IDX_W-1:0]                  cur_idx;
   logic [ADDR_W-1:0]                 cur_base;
   logic                              ld_en, upd_en;
   logic [DESC_WORDS-1:0][DATA_W-1:0] regs, upd_vec;

   assign upd_vec[WI_MODE_A] = eng_upd_mode_a;
   assign upd_vec[WI_MODE_B] = eng_upd_mode_b;
   assign upd_vec[WI_SRC]    = eng_upd_src;
   assign upd_vec[WI_DST]    = eng_upd_dst;
   assign upd_vec[WI_CNT_A]  = eng_upd_cnt_a;
   assign upd_vec[WI_CNT_B]  = eng_upd_cnt_b;

   xds_ctrl #(.ADDR_W(ADDR_W), .NWORDS(DESC_WORDS), .IW(IDX_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_base(act_base),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .eng_done(eng_done),
      .mem_req(mem_req), .mem_we(mem_we), .cur_idx(cur_idx), .cur_base(cur_base),
      .ld_en(ld_en), .upd_en(upd_en), .eng_start(eng_start),
      .busy(busy), .done_evt(done_evt)
   );

   xds_addr_gen #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .IDX_W(IDX_W)) i_addr (
      .base(cur_base), .idx(cur_idx), .addr(mem_addr)
   );

   xds_regfile #(.DATA_W(DATA_W), .NWORDS(DESC_WORDS), .IDX_W(IDX_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(cur_idx), .ld_data(mem_rdata),
      .upd_en(upd_en), .upd_data(upd_vec), .rd_idx(cur_idx),
      .regs(regs), .rd_data(mem_wdata)
   );

   assign eng_mode_a = regs[WI_MODE_A];
   assign eng_mode_b = regs[WI_MODE_B];
   assign eng_src    = regs[WI_SRC];
   assign eng_dst    = regs[WI_DST];
   assign eng_cnt_a  = regs[WI_CNT_A];
   assign eng_cnt_b  = regs[WI_CNT_B];

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> $stable(mem_addr) && $stable(mem_wdata)); // R6
   AST_EVT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |-> busy && !mem_req); // R8
endmodule

// File: tb/test_xfer_desc_seq.sv
module test_xfer_desc_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        act_req = 1'b0;
   logic [31:0] act_base = '0;
   logic        mem_req, mem_we, mem_gnt;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        eng_start, eng_done = 1'b0, busy, done_evt;
   logic [31:0] eng_mode_a, eng_mode_b, eng_src, eng_dst, eng_cnt_a, eng_cnt_b;
   logic [31:0] upd [6];

   always #4 clk = ~clk;

   int cyc = 0;
   int n_chk = 0, n_fail = 0;
   bit stall_mode = 1'b0;
   logic [31:0] mem [64];
   int   log_n = 0;
   logic [31:0] log_addr [64], log_data [64];
   bit   log_we [64];
   int   log_cyc [64];
   int   last_rv_cyc, last_wg_cyc, start_cyc, busy_rise, busy_fall;
   int   evt_cnt = 0, evt_wide = 0, quiet_err = 0, hold_err = 0;
   int   evt_cyc [8];
   logic [31:0] seen [6];
   int   eng_cnt = 0;
   bit   eng_act = 0, prev_stall = 0, prev_evt = 0, prev_busy = 0, prev_we = 0;
   logic [31:0] prev_addr = '0, prev_wd = '0;

   assign mem_gnt = mem_req && (!stall_mode || (cyc % 3 == 2));

   xfer_desc_seq i_xfer_desc_seq (
      .clk(clk), .rst_n(rst_n), .act_req(act_req), .act_base(act_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .eng_start(eng_start), .eng_mode_a(eng_mode_a), .eng_mode_b(eng_mode_b),
      .eng_src(eng_src), .eng_dst(eng_dst), .eng_cnt_a(eng_cnt_a), .eng_cnt_b(eng_cnt_b),
      .eng_done(eng_done), .eng_upd_mode_a(upd[0]), .eng_upd_mode_b(upd[1]),
      .eng_upd_src(upd[2]), .eng_upd_dst(upd[3]), .eng_upd_cnt_a(upd[4]),
      .eng_upd_cnt_b(upd[5]), .busy(busy), .done_evt(done_evt)
   );

   function automatic logic [31:0] xf(int k, logic [31:0] v);
      case (k)
         0: return v ^ 32'h0000_00A5;
         1: return v ^ 32'h0000_5A00;
         2: return v + 32'h10;
         3: return v + 32'h20;
         4: return v - 32'h1;
         default: return v + 32'h1;
      endcase
   endfunction

   always_comb begin
      upd[0] = xf(0, eng_mode_a); upd[1] = xf(1, eng_mode_b);
      upd[2] = xf(2, eng_src);    upd[3] = xf(3, eng_dst);
      upd[4] = xf(4, eng_cnt_a);  upd[5] = xf(5, eng_cnt_b);
   end

   // memory, engine and protocol monitors
   always @(posedge clk) begin
      cyc <= cyc + 1;
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
         if (log_n < 64) begin
            log_addr[log_n] = mem_addr; log_we[log_n] = mem_we;
            log_data[log_n] = mem_wdata; log_cyc[log_n] = cyc;
            log_n++;
         end
         if (mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
            last_wg_cyc = cyc;
         end else begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[mem_addr[7:2]];
         end
      end
      if (mem_rvalid) last_rv_cyc = cyc;
      if (prev_stall && (!mem_req || mem_addr != prev_addr || mem_we != prev_we ||
                         (mem_we && mem_wdata != prev_wd))) hold_err++;
      prev_stall = mem_req && !mem_gnt;
      prev_addr = mem_addr; prev_we = mem_we; prev_wd = mem_wdata;
      eng_done <= 1'b0;
      if (eng_act && mem_req) quiet_err++;
      if (eng_start) begin
         start_cyc = cyc; eng_act = 1; eng_cnt = 5;
         seen[0] = eng_mode_a; seen[1] = eng_mode_b; seen[2] = eng_src;
         seen[3] = eng_dst;    seen[4] = eng_cnt_a;  seen[5] = eng_cnt_b;
      end else if (eng_cnt > 0) begin
         eng_cnt--;
         if (eng_cnt == 0) eng_done <= 1'b1;
      end
      if (eng_done) eng_act = 0;
      if (done_evt) begin
         if (evt_cnt < 8) evt_cyc[evt_cnt] = cyc;
         evt_cnt++;
         if (prev_evt) evt_wide++;
      end
      prev_evt = done_evt;
      if (busy && !prev_busy) busy_rise = cyc;
      if (!busy && prev_busy) busy_fall = cyc;
      prev_busy = busy;
   end

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic fill(logic [31:0] base, int seed);
      for (int k = 0; k < 6; k++) mem[base[7:2] + k] = 32'h1000_0000 * (k + 1) + seed * 32'h111 + k;
   endtask

   task automatic do_act(logic [31:0] base, output int rc);
      @(negedge clk);
      act_req = 1'b1; act_base = base; rc = cyc;
      @(negedge clk);
      act_req = 1'b0;
   endtask

   task automatic wait_evt(int target);
      while (evt_cnt < target) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // single activation with full checks
   task automatic run_one(logic [31:0] base, int seed, bit stall, string tag);
      logic [31:0] init [6];
      int rc, e0;
      fill(base, seed);
      for (int k = 0; k < 6; k++) init[k] = mem[base[7:2] + k];
      stall_mode = stall; log_n = 0; e0 = evt_cnt; hold_err = 0; quiet_err = 0;
      do_act(base, rc);
      wait_evt(e0 + 1);
      chk(log_n == 12, "R2", "access count", log_n, 12);
      for (int k = 0; k < 6; k++) begin
         chk(log_addr[k] == base + 4 * k && !log_we[k], "R2", "read addr", log_addr[k], base + 4 * k);
         chk(seen[k] == init[k], tag, "engine value", seen[k], init[k]);
         chk(log_addr[6+k] == base + 4 * k && log_we[6+k], "R5", "write addr", log_addr[6+k], base + 4 * k);
         chk(log_data[6+k] == xf(k, init[k]), "R5", "write data", log_data[6+k], xf(k, init[k]));
         chk(mem[base[7:2] + k] == xf(k, init[k]), "R5", "memory word", mem[base[7:2] + k], xf(k, init[k]));
      end
      if (!stall)
         for (int k = 0; k < 5; k++)
            chk(log_cyc[k+1] == log_cyc[k] + 2, "R2", "read spacing", log_cyc[k+1] - log_cyc[k], 2);
      chk(start_cyc == last_rv_cyc + 1, "R3", "start cycle", start_cyc, last_rv_cyc + 1);
      chk(quiet_err == 0, "R4", "traffic while engine runs", quiet_err, 0);
      chk(hold_err == 0, "R6", "stalled request changed", hold_err, 0);
      chk(evt_cnt == e0 + 1, "R7", "event count", evt_cnt, e0 + 1);
      chk(evt_cyc[e0] == last_wg_cyc + 1, "R7", "event cycle", evt_cyc[e0], last_wg_cyc + 1);
      chk(evt_wide == 0, "R7", "event width", evt_wide, 0);
      chk(busy_rise == rc + 1, "R8", "busy rise", busy_rise, rc + 1);
      chk(busy_fall == evt_cyc[e0] + 1, "R8", "busy fall", busy_fall, evt_cyc[e0] + 1);
   endtask

   task automatic t_reset();
      chk(!busy && !done_evt && !mem_req && !eng_start, "R1", "outputs in reset",
          {busy, done_evt, mem_req, eng_start}, 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done_evt && !mem_req && !eng_start, "R1", "outputs after reset",
          {busy, done_evt, mem_req, eng_start}, 0);
   endtask

   task automatic t_pending();
      int rc, e0;
      logic [31:0] cinit [6], binit [6];
      stall_mode = 0; fill(32'h40, 7); fill(32'h80, 8); fill(32'hC0, 9);
      for (int k = 0; k < 6; k++) begin
         binit[k] = mem[32 + k]; cinit[k] = mem[48 + k];
      end
      log_n = 0; e0 = evt_cnt;
      do_act(32'h40, rc);
      repeat (3) @(negedge clk);
      do_act(32'h80, rc);
      do_act(32'hC0, rc);
      wait_evt(e0 + 2);
      repeat (30) @(negedge clk);
      chk(evt_cnt == e0 + 2, "R9", "activations served", evt_cnt, e0 + 2);
      chk(log_n == 24, "R9", "access count", log_n, 24);
      chk(log_cyc[12] == evt_cyc[e0] + 2, "R9", "pending launch cycle", log_cyc[12], evt_cyc[e0] + 2);
      chk(log_addr[12] == 32'h80, "R9", "pending base", log_addr[12], 32'h80);
      for (int k = 0; k < 6; k++) begin
         chk(mem[32 + k] == xf(k, binit[k]), "R9", "pending descriptor", mem[32 + k], xf(k, binit[k]));
         chk(mem[48 + k] == cinit[k], "R9", "dropped descriptor untouched", mem[48 + k], cinit[k]);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hDEAD_0000 + i;
      repeat (3) @(negedge clk);
      t_reset();
      run_one(32'h00, 1, 1'b0, "R3");
      run_one(32'h00, 2, 1'b1, "R10");
      run_one(32'h40, 3, 1'b1, "R3");
      t_pending();
      run_one(32'h00, 4, 1'b0, "R10");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule